// File: doc/BRIEF.md
# Memory-mapped GPIO bank

This block gives a small processor core 36 general-purpose pins, grouped into five ports. Four ports are 8 bits wide and the last port has only its low 4 bits. Each port has two registers on the core's byte-wide register bus: an output latch, and a direction register in which a 1 makes the pin an input and a 0 makes it a push-pull output. The pad cells are modelled as plain `pad_in` / `pad_out` / `pad_oe` / `pad_pullup` vectors. All pad inputs pass through a two-flop synchroniser before they reach the read path or the wake-up logic.

A read returns its data in the cycle after `bus_rd` is high. For an input pin the read returns the synchronised pad. For an output pin it also returns the pad, unless the core marks the access as the read half of a read-modify-write with `bus_rmw`. In that case the output latch is returned, so that a bit set, bit clear or complement done by the core writes back the intended pin levels, even if an outside load pulls a pin away from its latch. Port A also raises a level-sensitive wake-up request while any of its input pins is low.

The register bus is a simple strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read is always accepted, and its data stays on `bus_rdata` until the next read.

Top module: `gpio_bank`

## Requirements
- R1: While reset is active and straight after it, every direction bit is 1 (`pad_oe` all 0), every output latch is all ones (`pad_out` all 1), `bus_rdata` is 0 and `wake_req` is 0.
- R2: A write to the data address of port p (0x12 + 2p) loads `bus_wdata` into that port's latch, which drives `pad_out` bits [8p +: width] from the next cycle. The latch keeps its value until it is written again.
- R3: A write to the control address of port p (0x13 + 2p) sets the direction bits. A bit value of 1 makes the pin an input (`pad_oe` bit 0), and 0 makes it an output (`pad_oe` bit 1).
- R4: A read of a data address returns the pad level of each input pin, taken after two synchroniser flops. The value appears on `bus_rdata` in the cycle after `bus_rd`.
- R5: For an output pin, a read with `bus_rmw` = 0 returns the synchronised pad, and a read with `bus_rmw` = 1 returns the latch bit.
- R6: A read of a control address returns that port's direction register.
- R7: On port 4 (addresses 0x1A and 0x1B), bits [7:4] always read 0 and writes to them have no effect. Only 36 pad bits exist.
- R8: With the PULL_HIGH parameter set to 1, `pad_pullup` is high exactly on the pins configured as inputs, so pins float high after reset. With PULL_HIGH set to 0, it is always 0 and pins float after reset.
- R9: `wake_req` is high while at least one port-A pin whose direction bit is 1 reads low through the synchroniser. Output-configured pins and pins of other ports never raise it.
- R10: A write to an address outside 0x12–0x1B changes nothing, and a read of such an address returns 0.
- R11: A bit set, bit clear or complement done as a read with `bus_rmw` = 1 followed by a write changes only the selected latch bits, even when the pads differ from the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks a read as the first half of a read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| pad_in | input | 36 | Pad input levels |
| pad_out | output | 36 | Output latch values driven to the pads |
| pad_oe | output | 36 | Pad output enable, 1 = drive |
| pad_pullup | output | 36 | Weak pull-high enable |
| wake_req | output | 1 | Wake-up request from port A |

## Verification
The bound checker checks these on every cycle:
- a write to port A's data or control register shows on `pad_out` or `pad_oe` one cycle later;
- the latches stay put when there is no write;
- unmapped reads return zero;
- the upper nibble of port 4 reads zero;
- pull-ups appear only on input pins;
- a wake request always has at least one port-A input behind it.

Some behaviour can only be shown by the bench scenarios. These are the per-bit choice between pad and latch under the read-modify-write qualifier, the two-cycle synchroniser delay, the masking of port 4 on writes, and whole set, clear and complement sequences against pads that disagree with the latch.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Width of port p: every port is full width except the last one.
  function automatic int unsigned port_width(int unsigned p, int unsigned nports,
                                             int unsigned full_w, int unsigned last_w);
    return (p == nports - 1) ? last_w : full_w;
  endfunction

  function automatic int unsigned port_lsb(int unsigned p, int unsigned full_w);
    return p * full_w;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  // Resets to ones: pins are taken as high, so no false wake-up.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '1;
      q      <= '1;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned W  = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic [W-1:0]  pad_s,
  input  logic          rmw,
  output logic [W-1:0]  latch_q,
  output logic [W-1:0]  ctrl_q,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] rd_ctrl
);
  logic [W-1:0] src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
      ctrl_q  <= '1;
    end else begin
      if (wr_data) latch_q <= wdata[W-1:0];
      if (wr_ctrl) ctrl_q  <= wdata[W-1:0];
    end
  end

  // Per bit: input pins, or plain reads, see the pad; rmw reads of outputs see the latch.
  always_comb begin
    for (int i = 0; i < int'(W); i++)
      src[i] = (ctrl_q[i] | ~rmw) ? pad_s[i] : latch_q[i];
  end

  // Bits above W are not built and read as zero.
  always_comb begin
    rd_data        = '0;
    rd_data[W-1:0] = src;
    rd_ctrl        = '0;
    rd_ctrl[W-1:0] = ctrl_q;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned LAST_W    = 4,
  parameter int unsigned BASE_ADDR = 32'h12,
  parameter bit          PULL_HIGH = 1'b1,
  localparam int unsigned TOTAL_W  = DATA_W * (NUM_PORTS - 1) + LAST_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_rmw,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [TOTAL_W-1:0] pad_in,
  output logic [TOTAL_W-1:0] pad_out,
  output logic [TOTAL_W-1:0] pad_oe,
  output logic [TOTAL_W-1:0] pad_pullup,
  output logic               wake_req
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] NREG   = ADDR_W'(2 * NUM_PORTS);

  logic [ADDR_W-1:0]  off;
  logic               hit;
  logic [ADDR_W-2:0]  pidx;
  logic               is_ctrl;
  logic [TOTAL_W-1:0] pad_s;
  logic [TOTAL_W-1:0] ctrl_all;
  logic [DATA_W-1:0]  rdd [NUM_PORTS];
  logic [DATA_W-1:0]  rdc [NUM_PORTS];
  logic [DATA_W-1:0]  rd_sel;

  // Address decode: even offsets are data latches, odd offsets are direction registers.
  assign off     = bus_addr - BASE_A;
  assign hit     = (bus_addr >= BASE_A) && (off < NREG);
  assign pidx    = off[ADDR_W-1:1];
  assign is_ctrl = off[0];

  gpio_sync #(.W(TOTAL_W)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_s)
  );

  for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
    localparam int unsigned PW  = port_width(p, NUM_PORTS, DATA_W, LAST_W);
    localparam int unsigned LSB = port_lsb(p, DATA_W);
    logic sel, wr_d, wr_c;

    assign sel  = hit && (pidx == (ADDR_W-1)'(p));
    assign wr_d = bus_wr && sel && !is_ctrl;
    assign wr_c = bus_wr && sel && is_ctrl;

    gpio_port #(.W(PW), .DW(DATA_W)) port_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_d),
      .wr_ctrl (wr_c),
      .wdata   (bus_wdata),
      .pad_s   (pad_s[LSB +: PW]),
      .rmw     (bus_rmw),
      .latch_q (pad_out[LSB +: PW]),
      .ctrl_q  (ctrl_all[LSB +: PW]),
      .rd_data (rdd[p]),
      .rd_ctrl (rdc[p])
    );
  end

  assign pad_oe     = ~ctrl_all;
  assign pad_pullup = PULL_HIGH ? ctrl_all : '0;
  assign wake_req   = |(ctrl_all[DATA_W-1:0] & ~pad_s[DATA_W-1:0]);

  always_comb begin
    rd_sel = '0;
    for (int p = 0; p < int'(NUM_PORTS); p++)
      if (hit && (pidx == (ADDR_W-1)'(p)))
        rd_sel = is_ctrl ? rdc[p] : rdd[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_sel;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_PORTS = 5,
  parameter int unsigned LAST_W    = 4,
  parameter int unsigned BASE_ADDR = 32'h12,
  parameter int unsigned TOTAL_W   = 36
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [TOTAL_W-1:0] pad_out,
  input logic [TOTAL_W-1:0] pad_oe,
  input logic [TOTAL_W-1:0] pad_pullup,
  input logic               wake_req
);
  localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(BASE_ADDR + 2 * NUM_PORTS);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(BASE_ADDR + 2 * (NUM_PORTS - 1));

  a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FIRST) |=> pad_out[DATA_W-1:0] == $past(bus_wdata));

  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pad_out));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FIRST + 1'b1) |=> pad_oe[DATA_W-1:0] == ~$past(bus_wdata));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr < A_FIRST || bus_addr >= A_END)) |=> bus_rdata == '0);

  a_r7_last_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= A_LAST && bus_addr < A_END) |=> bus_rdata[DATA_W-1:LAST_W] == '0);

  a_r8_pull_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pullup & pad_oe) == '0);

  a_r9_wake_has_input: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (pad_oe[DATA_W-1:0] != '1));
endmodule

bind gpio_bank gpio_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS),
  .LAST_W(LAST_W), .BASE_ADDR(BASE_ADDR), .TOTAL_W(TOTAL_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pullup(pad_pullup), .wake_req(wake_req)
);

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
  localparam int TW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [39:0]   pad_wide = '1;
  logic [TW-1:0] pad_in, pad_out, pad_oe, pad_pullup;
  logic          wake_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign pad_in = pad_wide[TW-1:0];

  always #4 clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rmw(bus_rmw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup(pad_pullup), .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic m, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; bus_rmw = m;
    @(negedge clk); bus_rd = 1'b0; bus_rmw = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] pmask(int p);
    return (p == 4) ? 8'h0F : 8'hFF;
  endfunction

  function automatic logic [7:0] sl(logic [TW-1:0] v, int p);
    logic [39:0] w;
    w = {4'b0, v};
    return w[p*8 +: 8];
  endfunction

  initial begin
    logic [7:0] d, c, model;
    logic [TW-1:0] snap_o, snap_e;
    logic [7:0] pats [5];
    logic [7:0] bad  [5];
    pats = '{8'h00, 8'hFF, 8'h3C, 8'hC3, 8'h55};
    bad  = '{8'h00, 8'h11, 8'h1C, 8'hFF, 8'h80};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", 64'(pad_oe), 64'(0));
    chk("R1 out", 64'(pad_out), 64'({TW{1'b1}}));
    chk("R1 rdata", 64'(bus_rdata), 64'(0));
    chk("R1 wake", 64'(wake_req), 64'(0));
    chk("R8 reset pull", 64'(pad_pullup), 64'({TW{1'b1}}));

    // R2 R3 R6 R8 R7: sweep every value over every port
    for (int p = 0; p < 5; p++) begin
      for (int v = 0; v < 256; v++) begin
        c = 8'(v) ^ 8'h5A;
        wr(8'(8'h12 + 2*p), 8'(v));
        wr(8'(8'h13 + 2*p), c);
        chk("R2 latch", 64'(sl(pad_out, p)), 64'(8'(v) & pmask(p)));
        chk("R3 dir", 64'(sl(pad_oe, p)), 64'(~c & pmask(p)));
        chk("R8 pull", 64'(sl(pad_pullup, p)), 64'(c & pmask(p)));
        rd(8'(8'h13 + 2*p), 1'b0, d);
        chk("R6 ctrl read", 64'(d), 64'(c & pmask(p)));
      end
    end

    // R7 explicit on port 4
    wr(8'h1B, 8'h00);
    wr(8'h1A, 8'hFF);
    rd(8'h1A, 1'b1, d);
    chk("R7 data upper", 64'(d), 64'(8'h0F));
    rd(8'h1B, 1'b0, d);
    chk("R7 ctrl upper", 64'(d), 64'(8'h00));

    // R4 R5: upper nibble input, lower nibble output, latch A5
    for (int p = 0; p < 5; p++) begin
      wr(8'(8'h13 + 2*p), 8'hF0);
      wr(8'(8'h12 + 2*p), 8'hA5);
      for (int k = 0; k < 5; k++) begin
        @(negedge clk); pad_wide[p*8 +: 8] = pats[k];
        settle();
        rd(8'(8'h12 + 2*p), 1'b0, d);
        chk("R4 R5 plain read", 64'(d), 64'(pats[k] & pmask(p)));
        rd(8'(8'h12 + 2*p), 1'b1, d);
        chk("R5 rmw read", 64'(d), 64'(((pats[k] & 8'hF0) | 8'h05) & pmask(p)));
      end
      @(negedge clk); pad_wide[p*8 +: 8] = 8'hFF;
    end
    // R4 synchroniser delay: value not visible one cycle after change
    wr(8'h13, 8'hFF);
    settle();
    @(negedge clk); pad_wide[7:0] = 8'h00;
    bus_addr = 8'h12; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R4 sync delay", 64'(bus_rdata), 64'(8'hFF));
    @(negedge clk); pad_wide[7:0] = 8'hFF;
    settle();

    // R9 wake-up
    wr(8'h13, 8'hFF);
    settle();
    chk("R9 idle", 64'(wake_req), 64'(0));
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); pad_wide[i] = 1'b0;
      settle();
      chk("R9 input low", 64'(wake_req), 64'(1));
      wr(8'h13, ~(8'h01 << i));
      chk("R9 output low", 64'(wake_req), 64'(0));
      wr(8'h13, 8'hFF);
      @(negedge clk); pad_wide[i] = 1'b1;
      settle();
    end
    wr(8'h15, 8'hFF);
    @(negedge clk); pad_wide[8] = 1'b0;
    settle();
    chk("R9 other port", 64'(wake_req), 64'(0));
    @(negedge clk); pad_wide[8] = 1'b1;
    settle();

    // R10 unmapped addresses
    rd(8'h12, 1'b0, d);
    chk("R4 pads high", 64'(d), 64'(8'hFF));
    snap_o = pad_out; snap_e = pad_oe;
    for (int k = 0; k < 5; k++) begin
      wr(bad[k], 8'h00);
      chk("R10 write out", 64'(pad_out), 64'(snap_o));
      chk("R10 write oe", 64'(pad_oe), 64'(snap_e));
      rd(12'(8'h12), 1'b0, d);
      rd(bad[k], 1'b0, d);
      chk("R10 read zero", 64'(d), 64'(0));
    end

    // R11 read-modify-write on port 2 against disagreeing pads
    wr(8'h17, 8'h00);
    wr(8'h16, 8'h0F);
    @(negedge clk); pad_wide[23:16] = 8'hFF;
    settle();
    model = 8'h0F;
    for (int op = 0; op < 3; op++) begin
      rd(8'h16, 1'b1, d);
      chk("R11 rmw read", 64'(d), 64'(model));
      case (op)
        0: model = model | 8'h40;
        1: model = model & ~8'h01;
        default: model = ~model;
      endcase
      case (op)
        0: wr(8'h16, d | 8'h40);
        1: wr(8'h16, d & ~8'h01);
        default: wr(8'h16, ~d);
      endcase
      chk("R11 write back", 64'(sl(pad_out, 2)), 64'(model));
    end
    chk("R11 final", 64'(model), 64'(8'hB1));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule